// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Pending Bank

This block holds one 32-bit pending word for every processor in a multiprocessor system. The upper sixteen bits of each word are software interrupt requests. Bits 17 to 31 can be raised and dropped through two write windows. The lower bits record hardware level requests: sources routed from the system controller and each processor's local timer. A read window returns a processor's whole pending word.

For every processor the block also drives a registered 16-line priority level vector. Each line is the OR of two things: the hardware level lines that the system controller routes to that processor, and the software field of the pending word moved down by sixteen places.

The bank keeps one more flag for the system side. It follows the local timer inputs, so the system-level logic can mirror timer activity in its own pending state. Address decode across processor pages and system-level masking are done elsewhere.

Top module: `cpu_softint_bank`

## Requirements
- R1: After reset every pending word is zero, every level output line is zero and the system timer flag is zero.
- R2: A read with `rd_addr[3:2]` equal to 0 returns the pending word of processor `rd_cpu`. Indices 1, 2 and 3 return zero.
- R3: A write with `wr_addr[3:2]` equal to 2 ORs `wr_data & 0xFFFE0000` into the pending word of processor `wr_cpu`. Other processors are unchanged, and so are bits 0 and 16 and the lower field.
- R4: A write with `wr_addr[3:2]` equal to 1 forms a clear value. It starts from `wr_data`, gains bit 31 when `wr_data[14]` is 1, and is then ANDed with 0xFFFE0000. The pending word of `wr_cpu` loses those bits.
- R5: Writes with `wr_addr[3:2]` equal to 0 or 3 change no pending word.
- R6: Each `irq_lvl` slice is 16 bits, with slice c at bits [16c+15:16c]. At every clock edge the slice is loaded with `(hw_lvl slice | new pending[31:16]) & 0xFFFE`, where `hw_lvl` is the value sampled at that edge. Bit 0 of every slice is therefore always 0.
- R7: A rising edge on `tmr_in[c]` sets bit 10 of processor c's pending word. A falling edge clears that bit.
- R8: `tmr_sys_pend` becomes 1 when a timer input rises and 0 when one falls. When several timer inputs change in the same cycle, the highest-numbered changing processor decides.
- R9: When `src_valid` is high with `src_level` L from 1 to 15, bit L of processor `src_cpu`'s pending word is set if `src_assert` is 1 and cleared if it is 0. Level 0 has no effect.
- R10: Updates arriving in the same cycle are applied in this order: source event first, then timer edge, then the bus write. A timer edge therefore overrides a source event on the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_cpu | input | CW | Processor whose word is written |
| wr_addr | input | 4 | Byte address within the processor page |
| wr_data | input | 32 | Write data |
| rd_cpu | input | CW | Processor whose word is read |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| src_valid | input | 1 | System source event strobe |
| src_level | input | 4 | Level mapped to the source |
| src_assert | input | 1 | 1 sets, 0 clears the level bit |
| src_cpu | input | CW | Current target processor |
| tmr_in | input | NCPU | Local timer level per processor |
| hw_lvl | input | NCPU*16 | Routed hardware levels, 16 per processor |
| irq_lvl | output | NCPU*16 | Registered level lines, 16 per processor |
| tmr_sys_pend | output | 1 | Timer flag for the system controller |

## Verification
The bench covers the following corner cases, each with the failure it would expose:
- Clear write carrying bit 14. A design that ignores the alias leaves bit 31 pending. A design that applies the alias to a set write raises bit 31 by mistake.
- Writes containing bit 16 and bits of the low field. A design without the soft mask corrupts hardware requests or reports a level 0 line.
- A timer rise in the same cycle as a source deassert on the timer's level, with a set write to the same processor. A wrong update order loses the timer bit or the written soft bits.
- Two timers moving in opposite directions at once. A wrong precedence for the system flag shows up immediately.

// File: rtl/softint_pkg.sv
package softint_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned NLVL = 16;
   localparam logic [WORD_W-1:0] SOFT_FIELD = 32'hFFFE_0000;
   localparam logic [WORD_W-1:0] HARD_FIELD = 32'h0000_FFFE;
   localparam int unsigned ALIAS_SRC_BIT = 14;
   localparam int unsigned ALIAS_DST_BIT = 31;

   typedef enum logic [1:0] {
      WIN_STATUS = 2'd0,
      WIN_DROP   = 2'd1,
      WIN_RAISE  = 2'd2,
      WIN_SPARE  = 2'd3
   } win_e;

   function automatic logic [WORD_W-1:0] drop_value(input logic [WORD_W-1:0] d);
      logic [WORD_W-1:0] v;
      v = d;
      if (d[ALIAS_SRC_BIT]) v[ALIAS_DST_BIT] = 1'b1;
      return v & SOFT_FIELD;
   endfunction
endpackage

// File: rtl/softint_win_dec.sv
module softint_win_dec
   import softint_pkg::*;
#(
   parameter int unsigned NCPU = 4,
   parameter int unsigned CW = 2
) (
   input  logic                          wr_en,
   input  logic [CW-1:0]                 wr_cpu,
   input  logic [3:0]                    wr_addr,
   input  logic [WORD_W-1:0]             wr_data,
   output logic [NCPU-1:0][WORD_W-1:0]   raise_bits,
   output logic [NCPU-1:0][WORD_W-1:0]   drop_bits
);
   win_e win;
   logic [WORD_W-1:0] raise_v, drop_v;

   always_comb begin
      win = win_e'(wr_addr[3:2]);
      raise_v = '0;
      drop_v = '0;
      if (wr_en) begin
         case (win)
            WIN_RAISE: raise_v = wr_data & SOFT_FIELD;
            WIN_DROP:  drop_v = drop_value(wr_data);
            default: ;
         endcase
      end
   end

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      logic hit;
      assign hit = (wr_cpu == CW'(c));
      assign raise_bits[c] = hit ? raise_v : '0;
      assign drop_bits[c] = hit ? drop_v : '0;
   end
endmodule

// File: rtl/softint_pend_cell.sv
module softint_pend_cell
   import softint_pkg::*;
#(
   parameter int unsigned TMR_LVL = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_hit,
   input  logic [3:0]        src_level,
   input  logic              src_assert,
   input  logic              tmr_in,
   input  logic [WORD_W-1:0] raise_bits,
   input  logic [WORD_W-1:0] drop_bits,
   input  logic [NLVL-1:0]   hw_lvl,
   output logic [WORD_W-1:0] pend_q,
   output logic [NLVL-1:0]   irq_q,
   output logic              tmr_rise,
   output logic              tmr_fall
);
   logic              tmr_q;
   logic [WORD_W-1:0] pend_d;
   logic [NLVL-1:0]   irq_d;

   assign tmr_rise = tmr_in & ~tmr_q;
   assign tmr_fall = ~tmr_in & tmr_q;

   always_comb begin
      pend_d = pend_q;
      if (src_hit && (src_level != 4'd0)) pend_d[src_level] = src_assert;
      if (tmr_rise) pend_d[TMR_LVL] = 1'b1;
      else if (tmr_fall) pend_d[TMR_LVL] = 1'b0;
      pend_d = (pend_d | raise_bits) & ~drop_bits;
      irq_d = (hw_lvl | pend_d[WORD_W-1:NLVL]) & HARD_FIELD[NLVL-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         irq_q <= '0;
         tmr_q <= 1'b0;
      end else begin
         pend_q <= pend_d;
         irq_q <= irq_d;
         tmr_q <= tmr_in;
      end
   end

   AST_RAISE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|raise_bits) |=> ((pend_q & $past(raise_bits)) == $past(raise_bits))); // R3
   AST_DROP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|drop_bits) |=> ((pend_q & $past(drop_bits)) == '0)); // R4
   AST_TMR_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_rise |=> pend_q[TMR_LVL]); // R7
   AST_TMR_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_fall |=> !pend_q[TMR_LVL]); // R7
   AST_LVL0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q[0] == 1'b0) && (pend_q[0] == 1'b0) && (pend_q[NLVL] == 1'b0)); // R6
endmodule

// File: rtl/softint_rd_mux.sv
module softint_rd_mux
   import softint_pkg::*;
#(
   parameter int unsigned NCPU = 4,
   parameter int unsigned CW = 2
) (
   input  logic [CW-1:0]               rd_cpu,
   input  logic [3:0]                  rd_addr,
   input  logic [NCPU-1:0][WORD_W-1:0] pend,
   output logic [WORD_W-1:0]           rd_data
);
   always_comb begin
      rd_data = '0;
      if (win_e'(rd_addr[3:2]) == WIN_STATUS) begin
         for (int c = 0; c < NCPU; c++)
            if (rd_cpu == CW'(c)) rd_data = pend[c];
      end
   end
endmodule

// File: rtl/cpu_softint_bank.sv
module cpu_softint_bank
   import softint_pkg::*;
#(
   parameter int unsigned NCPU = 4,
   parameter int unsigned TMR_LVL = 10,
   localparam int unsigned CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CW-1:0]        wr_cpu,
   input  logic [3:0]           wr_addr,
   input  logic [31:0]          wr_data,
   input  logic [CW-1:0]        rd_cpu,
   input  logic [3:0]           rd_addr,
   output logic [31:0]          rd_data,
   input  logic                 src_valid,
   input  logic [3:0]           src_level,
   input  logic                 src_assert,
   input  logic [CW-1:0]        src_cpu,
   input  logic [NCPU-1:0]      tmr_in,
   input  logic [NCPU*16-1:0]   hw_lvl,
   output logic [NCPU*16-1:0]   irq_lvl,
   output logic                 tmr_sys_pend
);
   initial begin
      assert (NCPU >= 1) else $error("NCPU must be at least 1");
      assert (TMR_LVL >= 1 && TMR_LVL < NLVL) else $error("TMR_LVL out of range");
   end

   logic [NCPU-1:0][WORD_W-1:0] raise_bits, drop_bits, pend;
   logic [NCPU-1:0] rise, fall;
   logic sys_d;

   softint_win_dec #(.NCPU(NCPU), .CW(CW)) u_dec (
      .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_addr(wr_addr), .wr_data(wr_data),
      .raise_bits(raise_bits), .drop_bits(drop_bits)
   );

   for (genvar c = 0; c < NCPU; c++) begin : g_cell
      softint_pend_cell #(.TMR_LVL(TMR_LVL)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .src_hit(src_valid && (src_cpu == CW'(c))),
         .src_level(src_level), .src_assert(src_assert),
         .tmr_in(tmr_in[c]),
         .raise_bits(raise_bits[c]), .drop_bits(drop_bits[c]),
         .hw_lvl(hw_lvl[c*NLVL +: NLVL]),
         .pend_q(pend[c]), .irq_q(irq_lvl[c*NLVL +: NLVL]),
         .tmr_rise(rise[c]), .tmr_fall(fall[c])
      );
   end

   softint_rd_mux #(.NCPU(NCPU), .CW(CW)) u_rd (
      .rd_cpu(rd_cpu), .rd_addr(rd_addr), .pend(pend), .rd_data(rd_data)
   );

   always_comb begin
      sys_d = tmr_sys_pend;
      for (int c = 0; c < NCPU; c++) begin
         if (rise[c]) sys_d = 1'b1;
         else if (fall[c]) sys_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_sys_pend <= 1'b0;
      else tmr_sys_pend <= sys_d;
   end

   AST_RD_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[3:2] != 2'd0) |-> (rd_data == 32'd0)); // R2
   AST_SYS_FOLLOWS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ((|rise) && !(|fall)) |=> tmr_sys_pend); // R8
   AST_SYS_FOLLOWS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      ((|fall) && !(|rise)) |=> !tmr_sys_pend); // R8
endmodule

// File: tb/tb_cpu_softint_bank.sv
module tb_cpu_softint_bank;
   localparam int NCPU = 4;
   localparam int CW = 2;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] SMASK = 32'hFFFE_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [CW-1:0] wr_cpu = '0;
   logic [3:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [CW-1:0] rd_cpu = '0;
   logic [3:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic src_valid = 1'b0;
   logic [3:0] src_level = '0;
   logic src_assert = 1'b0;
   logic [CW-1:0] src_cpu = '0;
   logic [NCPU-1:0] tmr_in = '0;
   logic [NCPU*16-1:0] hw_lvl = '0;
   logic [NCPU*16-1:0] irq_lvl;
   logic tmr_sys_pend;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_softint_bank #(.NCPU(NCPU), .TMR_LVL(10)) dut (.*);

   typedef struct {
      string req;
      int kind;
      int idx;
      logic [31:0] exp;
   } item_t;

   item_t sb[$];
   int checks = 0;
   int errors = 0;
   logic [31:0] m_pend [NCPU];
   logic [NCPU-1:0] m_tprev = '0;
   logic m_sys = 1'b0;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Driver: apply the model for the coming edge and queue expectations
   task automatic tick(string req);
      item_t it;
      for (int c = 0; c < NCPU; c++) begin
         logic [31:0] n;
         n = m_pend[c];
         if (src_valid && src_cpu == CW'(c) && src_level != 0) n[src_level] = src_assert;
         if (tmr_in[c] && !m_tprev[c]) n[10] = 1'b1;
         if (!tmr_in[c] && m_tprev[c]) n[10] = 1'b0;
         if (wr_en && wr_cpu == CW'(c)) begin
            if (wr_addr[3:2] == 2'd2) n = n | (wr_data & SMASK);
            if (wr_addr[3:2] == 2'd1) begin
               logic [31:0] v;
               v = wr_data;
               if (v[14]) v[31] = 1'b1;
               n = n & ~(v & SMASK);
            end
         end
         m_pend[c] = n;
      end
      for (int c = 0; c < NCPU; c++)
         if (tmr_in[c] != m_tprev[c]) m_sys = tmr_in[c];
      m_tprev = tmr_in;
      for (int c = 0; c < NCPU; c++) begin
         it.req = req; it.kind = 1; it.idx = c;
         it.exp = {16'd0, (hw_lvl[c*16 +: 16] | m_pend[c][31:16]) & 16'hFFFE};
         sb.push_back(it);
      end
      it.req = req; it.kind = 0; it.idx = 0;
      it.exp = (rd_addr[3:2] == 2'd0) ? m_pend[rd_cpu] : 32'd0;
      sb.push_back(it);
      it.req = req; it.kind = 2; it.idx = 0; it.exp = {31'd0, m_sys};
      sb.push_back(it);
      @(posedge clk);
      @(negedge clk);
   endtask

   // Monitor: compare queued expectations after each edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            case (it.kind)
               0: check(it.req, "rd_data", rd_data, it.exp);
               1: check(it.req, $sformatf("irq_lvl[%0d]", it.idx),
                        {16'd0, irq_lvl[it.idx*16 +: 16]}, it.exp);
               default: check(it.req, "tmr_sys_pend", {31'd0, tmr_sys_pend}, it.exp);
            endcase
         end
      end
   end

   task automatic idle();
      wr_en = 1'b0; src_valid = 1'b0;
   endtask

   task automatic bus_write(int cpu, int idx, logic [31:0] d);
      wr_en = 1'b1; wr_cpu = CW'(cpu); wr_addr = 4'(idx << 2); wr_data = d;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCPU; c++) m_pend[c] = '0;
      @(negedge clk);
      // R1: reset state
      check("R1", "irq_lvl", irq_lvl[31:0], 32'd0);
      check("R1", "irq_lvl hi", irq_lvl[63:32], 32'd0);
      check("R1", "rd_data", rd_data, 32'd0);
      check("R1", "tmr_sys_pend", {31'd0, tmr_sys_pend}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R6 R2: set all soft bits of cpu0
      bus_write(0, 2, 32'hFFFF_FFFF); rd_cpu = 0; rd_addr = 0;
      tick("R3");
      idle(); tick("R2");
      // R3: bit 16 and low field masked, other cpus intact
      bus_write(2, 2, 32'h0005_ABCD); rd_cpu = 2;
      tick("R3");
      idle();
      // R4: bit 14 alias clears bit 31 only
      bus_write(0, 1, 32'h0000_4000); rd_cpu = 0;
      tick("R4");
      bus_write(0, 1, 32'h7FFE_0000);
      tick("R4");
      // R4: alias must not act on the set window
      bus_write(1, 2, 32'h0000_4000); rd_cpu = 1;
      tick("R4");
      // R5: windows 0 and 3 write nothing
      bus_write(2, 0, 32'hFFFF_FFFF); rd_cpu = 2;
      tick("R5");
      bus_write(2, 3, 32'hFFFF_FFFF);
      tick("R5");
      idle();
      // R2: spare read indices return zero
      rd_addr = 4'h4; tick("R2");
      rd_addr = 4'h8; tick("R2");
      rd_addr = 4'hC; tick("R2");
      rd_addr = 4'h0;
      // R6: hardware levels merged, bit 0 masked
      hw_lvl = 64'h1234_FFFF_0001_8421; tick("R6");
      hw_lvl = 64'hA5A5_0000_7777_0003; tick("R6");
      hw_lvl = '0; tick("R6");
      // R9: source events
      src_valid = 1'b1; src_cpu = 1; src_level = 5; src_assert = 1'b1; rd_cpu = 1;
      tick("R9");
      src_level = 0; tick("R9");
      src_level = 15; tick("R9");
      src_level = 5; src_assert = 1'b0; tick("R9");
      idle(); tick("R9");
      // R7 R8: timers
      tmr_in = 4'b1000; rd_cpu = 3; tick("R7");
      tick("R8");
      tmr_in = 4'b0010; tick("R8");
      tmr_in = 4'b1011; tick("R8");
      tmr_in = 4'b0000; tick("R7");
      // R10: source deassert vs timer rise on level 10, with a set write
      src_valid = 1'b1; src_cpu = 3; src_level = 10; src_assert = 1'b0;
      tmr_in = 4'b1000; bus_write(3, 2, 32'hC000_0000);
      tick("R10");
      idle(); tick("R10");
      // R10: source assert vs timer fall on level 10
      src_valid = 1'b1; src_cpu = 3; src_level = 10; src_assert = 1'b1;
      tmr_in = 4'b0000; bus_write(3, 1, 32'h4000_0000);
      tick("R10");
      idle(); tick("R10");
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule